// File: doc/BRIEF.md
# Non-Queued DMA Command Sequencer

This block runs the frame exchange for one non-queued DMA command on a serial storage host port. Software loads shadow task-file bytes through a write port. A write to the command byte while the port is idle issues one host-to-device register frame request and marks the port busy. The sequencer then watches the decoded types of received frames. When the data phase may begin, it starts an external DMA engine. It then waits for the device's closing register frame and copies that frame's status and error bytes into the shadow block.

The data phase depends on direction. A host-to-device transfer waits for a DMA Activate frame. A device-to-host transfer waits for the first data frame instead and never expects an activate. In both cases the software run bit must also be high, and it may rise before or after the command write. Completion status comes only from the closing register frame. A register frame that carries the error bit while the command is still waiting for, or inside, its data phase ends the command early.

Top module: `dma_cmd_seq`

## Requirements
- R1: A write to offset 7 while idle drives `tx_req` high for exactly one cycle, in the cycle after the write, with `tx_type` = 27h. It also sets status bit 7 (busy). Reads of offset 7 return the status byte.
- R2: Writes to offsets 0 to 6 only load shadow bytes, which read back at the same offset, and issue no frame. Offset 1 reads back as the error byte. Bit 0 of offset 6 selects the direction: 1 means device-to-host.
- R3: For host-to-device, only a DMA Activate frame (39h) opens the data phase. Data frames (46h), PIO setup frames (5Fh) and register frames without the error bit do not.
- R4: For device-to-host, the first data frame (46h) opens the data phase. A DMA Activate frame (39h) does not.
- R5: `dma_go` pulses for one cycle only once both the opening frame has been seen and `sw_run` is high, in either order. `dma_dir` then reports the latched direction.
- R6: After `dma_done`, a device-to-host register frame (34h) ends the command. Its status and error bytes are copied into the shadow block, `irq_done` pulses exactly when the frame's interrupt flag is set, and `irq_err` follows status bit 0.
- R7: A 34h frame with status bit 0 set, received before `dma_done`, ends the command. It pulses `irq_err` and copies status and error. It pulses `dma_abort` only if `dma_go` was already issued.
- R8: A 34h frame without the error bit, received before `dma_done`, changes neither the status nor the interrupts.
- R9: A 34h frame without the error bit that arrives in the same cycle as `dma_done` ends the command as in R6.
- R10: A write to offset 7 while a command is active issues no frame.
- R11: After reset all pulse outputs are low and the status and error bytes read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tf_we | input | 1 | Task-file write strobe |
| tf_waddr | input | 3 | Task-file write offset |
| tf_wdata | input | 8 | Task-file write byte |
| tf_raddr | input | 3 | Task-file read offset |
| tf_rdata | output | 8 | Registered task-file read byte |
| sw_run | input | 1 | Software run bit for the DMA engine |
| rx_valid | input | 1 | Received frame valid |
| rx_type | input | 8 | Received frame type code |
| rx_status | input | 8 | Status byte of a received register frame |
| rx_error | input | 8 | Error byte of a received register frame |
| rx_irq | input | 1 | Interrupt flag of a received register frame |
| tx_req | output | 1 | One-cycle transmit request |
| tx_type | output | 8 | Type code of the requested frame |
| dma_go | output | 1 | One-cycle data-phase start to the DMA engine |
| dma_dir | output | 1 | Latched direction, 1 = device-to-host |
| dma_abort | output | 1 | One-cycle abort to the DMA engine |
| dma_done | input | 1 | DMA engine finished the data phase |
| irq_done | output | 1 | One-cycle completion interrupt |
| irq_err | output | 1 | One-cycle error interrupt |

## Verification
During the data phase, the engine's `dma_done` and a device register frame can land in the same cycle. The sweep provokes this by driving both in one cycle. A clean frame must then complete the command at once (R9), while an error frame must still abort it (R7). The opening frame and the rising run bit can also coincide. Every direction, run-bit order, interrupt flag and ending is swept, and each case is judged by the pulses that follow and by the status and error bytes read back.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam logic [7:0] FT_H2D_REG = 8'h27;
  localparam logic [7:0] FT_D2H_REG = 8'h34;
  localparam logic [7:0] FT_ACTIVATE = 8'h39;
  localparam logic [7:0] FT_DATA = 8'h46;
  localparam logic [7:0] FT_PIO_SETUP = 8'h5F;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_RESP  = 2'd1,
    SQ_XFER  = 2'd2,
    SQ_FINAL = 2'd3
  } seq_state_e;

  typedef struct packed {
    logic d2h;
    logic act;
    logic data;
  } rx_kind_t;
endpackage

// File: rtl/dcs_rx_decode.sv
module dcs_rx_decode
  import dcs_pkg::*;
#(
  parameter int TW = 8
) (
  input  logic          rx_valid,
  input  logic [TW-1:0] rx_type,
  output rx_kind_t      kind
);
  always_comb begin
    kind.d2h  = rx_valid && (rx_type == TW'(FT_D2H_REG));
    kind.act  = rx_valid && (rx_type == TW'(FT_ACTIVATE));
    kind.data = rx_valid && (rx_type == TW'(FT_DATA));
  end
endmodule

// File: rtl/dcs_shadow.sv
module dcs_shadow #(
  parameter int DW      = 8,
  parameter int AW      = 3,
  parameter int CMD_OFS = 7,
  parameter int ERR_OFS = 1,
  parameter int DIR_OFS = 6,
  parameter int DIR_BIT = 0,
  parameter int BSY_BIT = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  input  logic          cmd_accept,
  input  logic          load_st,
  input  logic [DW-1:0] rx_status,
  input  logic [DW-1:0] rx_error,
  output logic [DW-1:0] rdata,
  output logic          dir_sel
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] mem_q;
  logic [DW-1:0] status_q;
  logic [DW-1:0] error_q;
  logic [AW-1:0] raddr_q;

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      error_q  <= '0;
      dir_sel  <= 1'b0;
      raddr_q  <= '0;
    end else begin
      raddr_q <= raddr;
      if (we && waddr == AW'(DIR_OFS)) dir_sel <= wdata[DIR_BIT];
      if (load_st) begin
        status_q <= rx_status;
        error_q  <= rx_error;
      end else if (cmd_accept) begin
        status_q[BSY_BIT] <= 1'b1;
      end
    end
  end

  always_comb begin
    if (raddr_q == AW'(CMD_OFS))      rdata = status_q;
    else if (raddr_q == AW'(ERR_OFS)) rdata = error_q;
    else                              rdata = mem_q;
  end

  a_r1_busy_set: assert property (@(posedge clk) disable iff (rst)
    cmd_accept && !load_st |=> status_q[BSY_BIT]);
  a_r6_status_copy: assert property (@(posedge clk) disable iff (rst)
    load_st |=> status_q == $past(rx_status) && error_q == $past(rx_error));
endmodule

// File: rtl/dcs_fsm.sv
module dcs_fsm
  import dcs_pkg::*;
#(
  parameter int AW      = 3,
  parameter int TW      = 8,
  parameter int CMD_OFS = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tf_we,
  input  logic [AW-1:0] tf_waddr,
  input  logic          dir_sel,
  input  logic          sw_run,
  input  rx_kind_t      kind,
  input  logic          rx_err_bit,
  input  logic          rx_irq,
  input  logic          dma_done,
  output logic          cmd_accept,
  output logic          load_st,
  output logic          tx_req,
  output logic [TW-1:0] tx_type,
  output logic          dma_go,
  output logic          dma_dir,
  output logic          dma_abort,
  output logic          irq_done,
  output logic          irq_err
);
  seq_state_e state;
  logic trig_seen;
  logic trig_now;
  logic err_frame;

  assign trig_now   = dma_dir ? kind.data : kind.act;
  assign err_frame  = kind.d2h && rx_err_bit;
  assign cmd_accept = tf_we && (tf_waddr == AW'(CMD_OFS)) && (state == SQ_IDLE);

  always_comb begin
    unique case (state)
      SQ_RESP:  load_st = err_frame;
      SQ_XFER:  load_st = err_frame || (kind.d2h && dma_done);
      SQ_FINAL: load_st = kind.d2h;
      default:  load_st = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= SQ_IDLE;
      trig_seen <= 1'b0;
      tx_req    <= 1'b0;
      tx_type   <= '0;
      dma_go    <= 1'b0;
      dma_dir   <= 1'b0;
      dma_abort <= 1'b0;
      irq_done  <= 1'b0;
      irq_err   <= 1'b0;
    end else begin
      tx_req    <= 1'b0;
      tx_type   <= '0;
      dma_go    <= 1'b0;
      dma_abort <= 1'b0;
      irq_done  <= 1'b0;
      irq_err   <= 1'b0;
      unique case (state)
        SQ_IDLE: begin
          if (cmd_accept) begin
            tx_req    <= 1'b1;
            tx_type   <= TW'(FT_H2D_REG);
            dma_dir   <= dir_sel;
            trig_seen <= 1'b0;
            state     <= SQ_RESP;
          end
        end
        SQ_RESP: begin
          if (err_frame) begin
            irq_err <= 1'b1;
            state   <= SQ_IDLE;
          end else if ((trig_seen || trig_now) && sw_run) begin
            dma_go <= 1'b1;
            state  <= SQ_XFER;
          end else if (trig_now) begin
            trig_seen <= 1'b1;
          end
        end
        SQ_XFER: begin
          if (err_frame) begin
            dma_abort <= 1'b1;
            irq_err   <= 1'b1;
            state     <= SQ_IDLE;
          end else if (dma_done && kind.d2h) begin
            irq_done <= rx_irq;
            state    <= SQ_IDLE;
          end else if (dma_done) begin
            state <= SQ_FINAL;
          end
        end
        SQ_FINAL: begin
          if (kind.d2h) begin
            irq_done <= rx_irq;
            irq_err  <= rx_err_bit;
            state    <= SQ_IDLE;
          end
        end
        default: state <= SQ_IDLE;
      endcase
    end
  end

  a_r1_tx_single: assert property (@(posedge clk) disable iff (rst)
    tx_req |=> !tx_req);
  a_r5_go_needs_run: assert property (@(posedge clk) disable iff (rst)
    dma_go |-> $past(sw_run));
  a_r7_abort_with_err: assert property (@(posedge clk) disable iff (rst)
    dma_abort |-> irq_err);
  a_r10_pulses_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({tx_req, dma_go, dma_abort, irq_done}));
endmodule

// File: rtl/dma_cmd_seq.sv
module dma_cmd_seq
  import dcs_pkg::*;
#(
  parameter int DW      = 8,
  parameter int AW      = 3,
  parameter int TW      = 8,
  parameter int CMD_OFS = 7,
  parameter int ERR_OFS = 1,
  parameter int DIR_OFS = 6,
  parameter int DIR_BIT = 0,
  parameter int BSY_BIT = 7,
  parameter int ERR_BIT = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tf_we,
  input  logic [AW-1:0] tf_waddr,
  input  logic [DW-1:0] tf_wdata,
  input  logic [AW-1:0] tf_raddr,
  output logic [DW-1:0] tf_rdata,
  input  logic          sw_run,
  input  logic          rx_valid,
  input  logic [TW-1:0] rx_type,
  input  logic [DW-1:0] rx_status,
  input  logic [DW-1:0] rx_error,
  input  logic          rx_irq,
  output logic          tx_req,
  output logic [TW-1:0] tx_type,
  output logic          dma_go,
  output logic          dma_dir,
  output logic          dma_abort,
  input  logic          dma_done,
  output logic          irq_done,
  output logic          irq_err
);
  rx_kind_t kind;
  logic     dir_sel;
  logic     cmd_accept;
  logic     load_st;

  dcs_rx_decode #(.TW(TW)) u_dec (
    .rx_valid (rx_valid),
    .rx_type  (rx_type),
    .kind     (kind)
  );

  dcs_shadow #(
    .DW(DW), .AW(AW), .CMD_OFS(CMD_OFS), .ERR_OFS(ERR_OFS),
    .DIR_OFS(DIR_OFS), .DIR_BIT(DIR_BIT), .BSY_BIT(BSY_BIT)
  ) u_shadow (
    .clk        (clk),
    .rst        (rst),
    .we         (tf_we),
    .waddr      (tf_waddr),
    .wdata      (tf_wdata),
    .raddr      (tf_raddr),
    .cmd_accept (cmd_accept),
    .load_st    (load_st),
    .rx_status  (rx_status),
    .rx_error   (rx_error),
    .rdata      (tf_rdata),
    .dir_sel    (dir_sel)
  );

  dcs_fsm #(.AW(AW), .TW(TW), .CMD_OFS(CMD_OFS)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .tf_we      (tf_we),
    .tf_waddr   (tf_waddr),
    .dir_sel    (dir_sel),
    .sw_run     (sw_run),
    .kind       (kind),
    .rx_err_bit (rx_status[ERR_BIT]),
    .rx_irq     (rx_irq),
    .dma_done   (dma_done),
    .cmd_accept (cmd_accept),
    .load_st    (load_st),
    .tx_req     (tx_req),
    .tx_type    (tx_type),
    .dma_go     (dma_go),
    .dma_dir    (dma_dir),
    .dma_abort  (dma_abort),
    .irq_done   (irq_done),
    .irq_err    (irq_err)
  );
endmodule

// File: tb/sim_dma_cmd_seq.sv
`timescale 1ns/1ps
module sim_dma_cmd_seq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tf_we = 1'b0;
  logic [2:0] tf_waddr = '0;
  logic [7:0] tf_wdata = '0;
  logic [2:0] tf_raddr = '0;
  logic [7:0] tf_rdata;
  logic       sw_run = 1'b0;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_type = '0;
  logic [7:0] rx_status = '0;
  logic [7:0] rx_error = '0;
  logic       rx_irq = 1'b0;
  logic       tx_req;
  logic [7:0] tx_type;
  logic       dma_go, dma_dir, dma_abort;
  logic       dma_done = 1'b0;
  logic       irq_done, irq_err;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dma_cmd_seq u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    tf_we = 1'b1; tf_waddr = a; tf_wdata = d;
    @(negedge clk);
    tf_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    tf_raddr = a;
    @(negedge clk);
    d = tf_rdata;
  endtask

  task automatic frame(input logic [7:0] t, input logic [7:0] st, input logic [7:0] er,
                       input logic irq, input logic done);
    @(negedge clk);
    rx_valid = 1'b1; rx_type = t; rx_status = st; rx_error = er; rx_irq = irq;
    dma_done = done;
    @(negedge clk);
    rx_valid = 1'b0; rx_type = '0; dma_done = 1'b0; rx_irq = 1'b0;
  endtask

  task automatic run_cmd(input logic dir, input logic early, input logic irq, input int ending);
    logic [7:0] v;
    logic [7:0] st;
    wr(3'd6, {7'd0, dir});
    sw_run = early;
    wr(3'd7, 8'hCA);
    chk("R1 tx_req", tx_req, 1);
    chk("R1 tx_type", tx_type, 8'h27);
    rd(3'd7, v);
    chk("R1 busy", v[7], 1);
    wr(3'd7, 8'hC8);
    chk("R10 no frame while busy", tx_req, 0);
    if (ending == 3) begin
      frame(8'h34, 8'h51, 8'h04, irq, 1'b0);
      chk("R7 err before data irq_err", irq_err, 1);
      chk("R7 no abort before data", dma_abort, 0);
      chk("R7 no irq_done", irq_done, 0);
      rd(3'd7, v); chk("R7 status copy", v, 8'h51);
      rd(3'd1, v); chk("R7 error copy", v, 8'h04);
      sw_run = 1'b0;
      return;
    end
    frame(dir ? 8'h39 : 8'h46, 8'h00, 8'h00, 1'b0, 1'b0);
    chk(dir ? "R4 activate ignored" : "R3 data ignored", dma_go, 0);
    frame(8'h5F, 8'h00, 8'h00, 1'b0, 1'b0);
    chk("R3 pio setup ignored", dma_go, 0);
    frame(8'h34, 8'h50, 8'h00, 1'b1, 1'b0);
    chk("R8 clean frame no irq", irq_done, 0);
    rd(3'd7, v); chk("R8 busy kept", v[7], 1);
    frame(dir ? 8'h46 : 8'h39, 8'h00, 8'h00, 1'b0, 1'b0);
    if (early) begin
      chk("R5 go same cycle", dma_go, 1);
    end else begin
      chk("R5 no go without run", dma_go, 0);
      @(negedge clk); sw_run = 1'b1;
      @(negedge clk);
      chk("R5 go after run", dma_go, 1);
    end
    chk("R5 dma_dir", dma_dir, dir);
    st = {1'b0, 1'b1, 2'b00, dir, 2'b00, 1'b0};
    if (ending == 0) begin
      frame(8'h34, 8'h50, 8'h00, 1'b1, 1'b0);
      chk("R8 clean frame in data phase", irq_done, 0);
      @(negedge clk); dma_done = 1'b1;
      @(negedge clk); dma_done = 1'b0;
      frame(8'h34, st, 8'h00, irq, 1'b0);
      chk("R6 irq_done", irq_done, irq);
      chk("R6 irq_err", irq_err, 0);
      rd(3'd7, v); chk("R6 status copy", v, st);
      rd(3'd1, v); chk("R6 error copy", v, 0);
    end else if (ending == 1) begin
      frame(8'h34, 8'h51, 8'h84, irq, 1'b1);
      chk("R7 abort", dma_abort, 1);
      chk("R7 irq_err", irq_err, 1);
      chk("R7 no irq_done", irq_done, 0);
      rd(3'd7, v); chk("R7 status copy", v, 8'h51);
      rd(3'd1, v); chk("R7 error copy", v, 8'h84);
    end else begin
      frame(8'h34, st, 8'h22, irq, 1'b1);
      chk("R9 irq_done", irq_done, irq);
      chk("R9 no abort", dma_abort, 0);
      rd(3'd7, v); chk("R9 status copy", v, st);
      rd(3'd1, v); chk("R9 error copy", v, 8'h22);
    end
    sw_run = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R11 tx_req", tx_req, 0);
    chk("R11 dma_go", dma_go, 0);
    chk("R11 irq", {irq_done, irq_err, dma_abort}, 0);
    rd(3'd7, v); chk("R11 status", v, 0);
    rd(3'd1, v); chk("R11 error", v, 0);
    for (int a = 0; a < 7; a++) begin
      wr(3'(a), 8'(8'h30 + a));
      chk("R2 no frame", tx_req, 0);
    end
    for (int a = 0; a < 7; a++) begin
      rd(3'(a), v);
      if (a == 1) chk("R2 offset1 is error", v, 0);
      else chk("R2 shadow readback", v, 8'h30 + a);
    end
    for (int d = 0; d < 2; d++)
      for (int e = 0; e < 2; e++)
        for (int i = 0; i < 2; i++)
          for (int n = 0; n < 4; n++)
            run_cmd(d[0], e[0], i[0], n);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule